// File: doc/BRIEF.md
# Keyed System Control Register

This block is a 32-bit control register on a simple write/read port that guards itself with a write key. A bus write changes nothing unless its upper half carries the unlock value 0x05FA. An accepted write loads a 3-bit interrupt priority grouping value and can fire one of two reset request strobes. One strobe asks for a reset of the whole system, peripherals and core together. The other asks for a reset of the processor core alone and leaves peripheral settings in place.

The grouping value is held as state and is driven out continuously. The two reset bits are never stored: an accepted write that sets one of them makes a one-cycle pulse on the matching output. The read port always shows a fixed tag in the upper half, different from the write key. Software must therefore substitute the key on every read-modify-write, and a value read back and written unchanged is rejected.

Top module: `keyed_sysctl_reg`

## Requirements
- R1: During and right after reset the grouping output is 0, both reset strobes are low, and the read word is 0xFA050000.
- R2: A write whose bits 31:16 equal 0x05FA loads bits 10:8 into the grouping field. The new value is visible on the grouping output and in read bits 10:8 from the cycle after the write edge.
- R3: A write whose bits 31:16 hold any other value leaves the grouping field unchanged and raises neither strobe. This includes the read tag 0xFA05.
- R4: An accepted write with bit 2 set raises the system reset strobe for exactly the cycle after the write edge.
- R5: An accepted write with bit 0 set and bit 2 clear raises the core reset strobe for exactly the cycle after the write edge.
- R6: An accepted write with both bit 2 and bit 0 set raises only the system reset strobe. The two strobes are never high together.
- R7: A strobe is high only in a cycle that directly follows an accepted write requesting it. Without a further such write it falls after one cycle.
- R8: The read word is the tag 0xFA05 in bits 31:16 and the grouping field in bits 10:8, with 0 in every other bit, reset bits 2 and 0 included.
- R9: A read-modify-write that keeps bits 10:8 from the read word and replaces bits 31:16 with 0x05FA keeps the grouping value. The same write can also fire a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write word: key in 31:16, grouping in 10:8, system reset in 2, core reset in 0 |
| rd_data | output | 32 | Current read word |
| prio_group | output | 3 | Stored priority grouping value |
| sys_rst_req | output | 1 | One-cycle system reset request |
| core_rst_req | output | 1 | One-cycle core-only reset request |

## Verification
A bad key compare shows up one cycle after the offending write. Either the grouping output moves to the write's bits 10:8, or a stray strobe appears. A stuck strobe register is seen in the second cycle after its request, when the line is still high. A lost grouping value shows on both prio_group and rd_data in the first cycle after the write. The bench compares every port every cycle against a model, so each of these faults is caught in the cycle it first becomes visible.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int WORD_W     = 32;
  localparam int KEY_W      = 16;
  localparam int KEY_LSB    = 16;
  localparam int GRP_W      = 3;
  localparam int GRP_LSB    = 8;
  localparam int SYS_BIT    = 2;
  localparam int CORE_BIT   = 0;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h05FA;
  localparam logic [KEY_W-1:0] READ_TAG   = 16'hFA05;

  function automatic logic [KEY_W-1:0] key_of(input logic [WORD_W-1:0] w);
    return w[KEY_LSB +: KEY_W];
  endfunction

  function automatic logic [GRP_W-1:0] group_of(input logic [WORD_W-1:0] w);
    return w[GRP_LSB +: GRP_W];
  endfunction

  function automatic logic [WORD_W-1:0] readback(input logic [KEY_W-1:0] tag,
                                                 input logic [GRP_W-1:0] grp);
    logic [WORD_W-1:0] r;
    r = '0;
    r[KEY_LSB +: KEY_W] = tag;
    r[GRP_LSB +: GRP_W] = grp;
    return r;
  endfunction
endpackage

// File: rtl/sysctl_key_gate.sv
module sysctl_key_gate
  import sysctl_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              accept,
  output logic              sys_hit,
  output logic              core_hit
);
  localparam logic [WORD_W-1:0] USED_MASK =
    (({WORD_W{1'b0}} | {KEY_W{1'b1}}) << KEY_LSB) |
    (({WORD_W{1'b0}} | {GRP_W{1'b1}}) << GRP_LSB) |
    (WORD_W'(1) << SYS_BIT) | (WORD_W'(1) << CORE_BIT);

  logic unused_wr_bits;
  assign unused_wr_bits = ^(wr_data & ~USED_MASK);

  assign accept   = wr_en && (key_of(wr_data) == KEY);
  // system request wins over core request
  assign sys_hit  = accept && wr_data[SYS_BIT];
  assign core_hit = accept && wr_data[CORE_BIT] && !wr_data[SYS_BIT];
endmodule

// File: rtl/sysctl_group_store.sv
module sysctl_group_store
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [GRP_W-1:0] new_grp,
  output logic [GRP_W-1:0] grp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grp <= '0;
    else if (accept) grp <= new_grp;
  end

  assert_hold_on_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(grp));
  assert_load_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> grp == $past(new_grp));
endmodule

// File: rtl/sysctl_strobe_gen.sv
module sysctl_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_hit,
  input  logic core_hit,
  output logic sys_pulse,
  output logic core_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_pulse  <= 1'b0;
      core_pulse <= 1'b0;
    end else begin
      sys_pulse  <= sys_hit;
      core_pulse <= core_hit;
    end
  end

  assert_sys_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_hit |=> !sys_pulse);
  assert_core_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !core_hit |=> !core_pulse);
  assert_sys_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_hit |=> sys_pulse);
  assert_core_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_hit |=> core_pulse);
endmodule

// File: rtl/keyed_sysctl_reg.sv
module keyed_sysctl_reg
  import sysctl_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = UNLOCK_KEY,
  parameter logic [KEY_W-1:0] TAG = READ_TAG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [GRP_W-1:0]  prio_group,
  output logic              sys_rst_req,
  output logic              core_rst_req
);
  logic accept, sys_hit, core_hit;

  sysctl_key_gate #(.KEY(KEY)) u_gate (
    .wr_en(wr_en), .wr_data(wr_data),
    .accept(accept), .sys_hit(sys_hit), .core_hit(core_hit)
  );

  sysctl_group_store u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .new_grp(group_of(wr_data)), .grp(prio_group)
  );

  sysctl_strobe_gen u_strobe (
    .clk(clk), .rst_n(rst_n), .sys_hit(sys_hit), .core_hit(core_hit),
    .sys_pulse(sys_rst_req), .core_pulse(core_rst_req)
  );

  assign rd_data = readback(TAG, prio_group);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sys_rst_req, core_rst_req}));
  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[SYS_BIT] == 1'b0 && rd_data[CORE_BIT] == 1'b0 &&
    rd_data[KEY_LSB +: KEY_W] == TAG);
  assert_bad_key_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key_of(wr_data) != KEY) |=> !sys_rst_req && !core_rst_req);
endmodule

// File: tb/keyed_sysctl_reg_tb.sv
module keyed_sysctl_reg_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [31:0] rd;
    logic [2:0]  grp;
    logic        sys;
    logic        core;
    logic [7:0]  req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0]  prio_group;
  logic        sys_rst_req, core_rst_req;

  int   tests = 0, fails = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];
  logic [2:0] model_grp = 3'd0;

  keyed_sysctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .prio_group(prio_group),
    .sys_rst_req(sys_rst_req), .core_rst_req(core_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(input logic [2:0] g);
    return {16'hFA05, 5'b00000, g, 8'h00};
  endfunction

  task automatic compare(input exp_t e);
    tests++;
    if (rd_data !== e.rd || prio_group !== e.grp ||
        sys_rst_req !== e.sys || core_rst_req !== e.core) begin
      fails++;
      $display("FAIL R%0d: rd=%h grp=%0d sys=%b core=%b expected rd=%h grp=%0d sys=%b core=%b",
               e.req, rd_data, prio_group, sys_rst_req, core_rst_req,
               e.rd, e.grp, e.sys, e.core);
    end
  endtask

  // driver: one cycle of stimulus at the falling edge, one expected item
  task automatic drive(input logic we, input logic [31:0] d, input int req);
    exp_t e;
    logic acc;
    @(negedge clk);
    wr_en   = we;
    wr_data = d;
    acc = we && (d[31:16] == 16'h05FA);
    if (acc) model_grp = d[10:8];
    e.grp  = model_grp;
    e.sys  = acc && d[2];
    e.core = acc && d[0] && !d[2];
    e.rd   = model_read(model_grp);
    e.req  = 8'(req);
    sb_q.push_back(e);
  endtask

  // monitor: after each rising edge, compare against the oldest item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    exp_t r1;
    logic [31:0] rmw;
    repeat (3) @(posedge clk);
    #1;
    r1 = '{rd: 32'hFA050000, grp: 3'd0, sys: 1'b0, core: 1'b0, req: 8'd1};
    compare(r1); // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 32'h0, 1);                         // R1 after reset
    drive(1'b1, 32'h05FA_0500, 2);                 // R2 group 5
    drive(1'b0, 32'h0, 8);                         // R8 readback of 5
    drive(1'b1, 32'h05FA_0700, 2);                 // R2 group 7
    drive(1'b1, 32'hFA05_0205, 3);                 // R3 read tag rejected
    drive(1'b1, 32'h05FB_0004, 3);                 // R3 near key rejected
    drive(1'b1, 32'h0000_0101, 3);                 // R3 zero key rejected
    drive(1'b0, 32'h05FA_0004, 3);                 // R3 key without wr_en
    drive(1'b1, 32'h05FA_0704, 4);                 // R4 system strobe
    drive(1'b0, 32'h0, 7);                         // R7 falls after one cycle
    drive(1'b1, 32'h05FA_0701, 5);                 // R5 core strobe
    drive(1'b0, 32'h0, 7);                         // R7
    drive(1'b1, 32'h05FA_0305, 6);                 // R6 both set, system only
    drive(1'b0, 32'h0, 6);                         // R6
    drive(1'b1, 32'h05FA_0304, 7);                 // R7 back-to-back requests
    drive(1'b1, 32'h05FA_0304, 7);                 // R7
    drive(1'b0, 32'h0, 7);                         // R7
    drive(1'b1, 32'h05FA_0000, 2);                 // R2 group 0
    drive(1'b1, 32'h05FA_0600, 2);                 // R2 group 6
    drive(1'b0, 32'h0, 8);                         // R8
    @(negedge clk);
    #1;
    rmw = rd_data;
    rmw[31:16] = 16'h05FA;
    rmw[0] = 1'b1;
    drive(1'b1, rmw, 9);                           // R9 keeps 6, core strobe
    drive(1'b1, {16'h05FA, rd_data[15:0]} | 32'h4, 9); // R9 system strobe
    drive(1'b0, 32'h0, 9);                         // R9
    drive(1'b0, 32'h0, 8);                         // R8
    repeat (3) @(posedge clk);
    #2;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule